// File: doc/BRIEF.md
# Four-Bank Pin Controller with Set/Clear Access

This block gives software control of four banks of chip pins through a single-cycle word-addressed register bus. Banks 0, 1 and 2 are bidirectional and are 8, 24 and 13 pins wide. Bank 3 combines three kinds of pin:

- 6 bidirectional pins;
- a group of input-only lines;
- 24 output-only lines.

A further 32-bit routing word is held for the pad multiplexers around the block.

Software never writes an output level or a direction directly. Every stored word has a pair of strobe addresses. Ones written to the raise address set bits. Ones written to the lower address clear bits. Zero bits leave the stored value alone.

Each stored word is read back at its own state address. Pad inputs pass through two flops before software can see them.

Bank 3 does not use a plain bit-per-pin layout:

- The control bits of its bidirectional pins sit at bits 25 to 30.
- Their output enables sit in bank 2's direction word.
- Their input levels are placed among the input-only lines in one shared input word.

Top module: `gpio_multiport`

## Requirements
- R1: After reset, every output enable, pad output level, output-only line and routing bit is 0, and every state address reads 0 while the pad inputs are held low.
- R2: A write to a raise address (bank 0 output 0x044, bank 1 output 0x064, bank 0 direction 0x050, bank 1 direction 0x070) sets each bit that is 1 in the data. Bits that are 0 keep their value. The result drives the pads on the cycle after the write edge.
- R3: A write to a lower address (bank 0 output 0x048, bank 1 output 0x068, bank 0 direction 0x054, bank 1 direction 0x074) clears each bit that is 1 in the data and leaves the other bits unchanged.
- R4: Direction bit n drives the output enable of pin n; 1 means the pin is driven. Direction reads back at 0x058 (bank 0) and 0x078 (bank 1). Output level reads back at 0x04C (bank 0) and 0x06C (bank 1), with pin n at bit n.
- R5: Every raise or lower address reads as 0.
- R6: Bank 2 output level is raised at 0x020 and lowered at 0x024, with pin n at bit n; it has no readback. Bank 2 direction uses 0x010 (raise), 0x014 (lower) and 0x018 (state), with pin n at bit n. The routing word uses 0x028 (raise), 0x02C (lower) and 0x030 (state), and drives `route_sel_o`.
- R7: Bank 3 bidirectional pin n (n = 0..5) is controlled at bit n+25 in three places. Its output level is in the bank 3 output word (raise 0x004, lower 0x008, state 0x00C). Its output enable is in the bank 2 direction word (0x010/0x014/0x018).
- R8: Bits 0 to 23 of the bank 3 output word drive the 24 output-only lines, and read back at the same positions at 0x00C.
- R9: A pad input change shows in the input words after the second rising edge and not before. The input words are bank 0 at 0x040, bank 1 at 0x060 and bank 2 at 0x01C, with pin n at bit n.
- R10: The bank 3 input word is read at 0x000. Input-only line k appears at bit k for k in 0..9, 15..23 and 25..27. Bidirectional pins 0 to 4 appear at bits 10 to 14, and pin 5 appears at bit 24. Input-only lines 10..14 and 24 have no effect.
- R11: Addresses that are outside the map read 0, and writes to them change nothing. This covers any address with a nonzero bit 0, 1 or 7, and any unlisted word.
- R12: Data bits beyond a bank's width (and bits 13 to 24 of the bank 2 direction word) are dropped on a write. Those bits read 0 and drive no pad.

Bank 3 output-word layout (R7, R8):

| Bits | Drives |
|------|--------|
| 0–23 | output-only lines 0–23 |
| 24 | unused, reads 0 |
| 25–30 | bidirectional pins 0–5 |

Bank 3 input word at 0x000 (R10):

| Bits | Source |
|------|--------|
| 0–9 | input-only lines 0–9 |
| 10–14 | bidirectional pins 0–4 |
| 15–23 | input-only lines 15–23 |
| 24 | bidirectional pin 5 |
| 25–27 | input-only lines 25–27 |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | ADDR_W (8) | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the current address, combinational |
| b0_pad_i | input | 8 | Bank 0 pad input levels |
| b0_pad_o | output | 8 | Bank 0 pad output levels |
| b0_pad_oe_o | output | 8 | Bank 0 output enables |
| b1_pad_i | input | 24 | Bank 1 pad input levels |
| b1_pad_o | output | 24 | Bank 1 pad output levels |
| b1_pad_oe_o | output | 24 | Bank 1 output enables |
| b2_pad_i | input | 13 | Bank 2 pad input levels |
| b2_pad_o | output | 13 | Bank 2 pad output levels |
| b2_pad_oe_o | output | 13 | Bank 2 output enables |
| b3_io_i | input | 6 | Bank 3 bidirectional pin input levels |
| b3_io_o | output | 6 | Bank 3 bidirectional pin output levels |
| b3_io_oe_o | output | 6 | Bank 3 bidirectional pin output enables |
| b3_din_i | input | 28 | Bank 3 input-only lines (10..14 and 24 unused) |
| b3_dout_o | output | 24 | Bank 3 output-only lines |
| route_sel_o | output | 32 | Routing word for the surrounding pad multiplexers |

## Verification
The properties assume that a raise address and a lower address are never written in the same cycle. The bus carries one access per cycle, so this holds by the way the bus works.

The properties also assume that the address and write data stay steady from just after one rising edge until the next. The stimulus changes the bus only one time unit after an edge.

The properties make no assumption about the pad inputs. The stimulus still changes the pad inputs only after an edge and then waits out the two synchronizer stages before it reads them back. This includes the bank 3 input-only lines that share bit positions with the bidirectional pins.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;

    localparam int DATA_W    = 32;
    localparam int WIDX_W    = 5;   // word index bits, byte address bits [6:2]

    localparam int B0_W      = 8;
    localparam int B1_W      = 24;
    localparam int B2_W      = 13;
    localparam int B3_IO_W   = 6;
    localparam int B3_DIN_W  = 28;
    localparam int B3_DOUT_W = 24;

    // bank 3 bidirectional control bits start here (output word and bank 2 direction word)
    localparam int B3_IO_LSB    = 25;
    // bank 3 bidirectional pins 0..4 land here in the bank 3 input word
    localparam int B3_IN_LO_LSB = 10;
    // the last bidirectional pin lands here
    localparam int B3_IN_LAST   = 24;

    localparam int CTL_W   = B3_IO_LSB + B3_IO_W;
    localparam int ROUTE_W = DATA_W;
    localparam int SYNC_W  = B0_W + B1_W + B2_W + B3_IO_W + B3_DIN_W;

    localparam int SY_B0  = 0;
    localparam int SY_B1  = SY_B0 + B0_W;
    localparam int SY_B2  = SY_B1 + B1_W;
    localparam int SY_IO  = SY_B2 + B2_W;
    localparam int SY_DIN = SY_IO + B3_IO_W;

    localparam logic [CTL_W-1:0] IO_CTL_BITS  = CTL_W'((1 << B3_IO_W) - 1) << B3_IO_LSB;
    localparam logic [CTL_W-1:0] B2_DIR_KEEP  = CTL_W'((1 << B2_W) - 1) | IO_CTL_BITS;
    localparam logic [CTL_W-1:0] B3_OUT_KEEP  = CTL_W'((1 << B3_DOUT_W) - 1) | IO_CTL_BITS;
    localparam logic [B3_DIN_W-1:0] B3_DIN_VALID =
        ~(B3_DIN_W'((1 << (B3_IO_W - 1)) - 1) << B3_IN_LO_LSB) &
        ~(B3_DIN_W'(1) << B3_IN_LAST);

    // word indices; software depends on these positions
    localparam logic [WIDX_W-1:0] WI_B3_IN   = 5'd0;
    localparam logic [WIDX_W-1:0] WI_B3_OSET = 5'd1;
    localparam logic [WIDX_W-1:0] WI_B3_OCLR = 5'd2;
    localparam logic [WIDX_W-1:0] WI_B3_OST  = 5'd3;
    localparam logic [WIDX_W-1:0] WI_B2_DSET = 5'd4;
    localparam logic [WIDX_W-1:0] WI_B2_DCLR = 5'd5;
    localparam logic [WIDX_W-1:0] WI_B2_DST  = 5'd6;
    localparam logic [WIDX_W-1:0] WI_B2_IN   = 5'd7;
    localparam logic [WIDX_W-1:0] WI_B2_OSET = 5'd8;
    localparam logic [WIDX_W-1:0] WI_B2_OCLR = 5'd9;
    localparam logic [WIDX_W-1:0] WI_RT_SET  = 5'd10;
    localparam logic [WIDX_W-1:0] WI_RT_CLR  = 5'd11;
    localparam logic [WIDX_W-1:0] WI_RT_ST   = 5'd12;
    localparam logic [WIDX_W-1:0] WI_B0_IN   = 5'd16;
    localparam logic [WIDX_W-1:0] WI_B0_OSET = 5'd17;
    localparam logic [WIDX_W-1:0] WI_B0_OCLR = 5'd18;
    localparam logic [WIDX_W-1:0] WI_B0_OST  = 5'd19;
    localparam logic [WIDX_W-1:0] WI_B0_DSET = 5'd20;
    localparam logic [WIDX_W-1:0] WI_B0_DCLR = 5'd21;
    localparam logic [WIDX_W-1:0] WI_B0_DST  = 5'd22;
    localparam logic [WIDX_W-1:0] WI_B1_IN   = 5'd24;
    localparam logic [WIDX_W-1:0] WI_B1_OSET = 5'd25;
    localparam logic [WIDX_W-1:0] WI_B1_OCLR = 5'd26;
    localparam logic [WIDX_W-1:0] WI_B1_OST  = 5'd27;
    localparam logic [WIDX_W-1:0] WI_B1_DSET = 5'd28;
    localparam logic [WIDX_W-1:0] WI_B1_DCLR = 5'd29;
    localparam logic [WIDX_W-1:0] WI_B1_DST  = 5'd30;

    typedef struct packed {
        logic b0_oset; logic b0_oclr; logic b0_dset; logic b0_dclr;
        logic b1_oset; logic b1_oclr; logic b1_dset; logic b1_dclr;
        logic b2_oset; logic b2_oclr; logic b2_dset; logic b2_dclr;
        logic b3_oset; logic b3_oclr;
        logic rt_set;  logic rt_clr;
    } wr_stb_t;

    typedef struct packed {
        logic [B0_W-1:0]     b0_in;
        logic [B0_W-1:0]     b0_out;
        logic [B0_W-1:0]     b0_dir;
        logic [B1_W-1:0]     b1_in;
        logic [B1_W-1:0]     b1_out;
        logic [B1_W-1:0]     b1_dir;
        logic [B2_W-1:0]     b2_in;
        logic [CTL_W-1:0]    b2_dir;
        logic [ROUTE_W-1:0]  route;
        logic [B3_DIN_W-1:0] b3_in;
        logic [CTL_W-1:0]    b3_out;
    } rd_view_t;

endpackage

// File: rtl/gpio_mp_sync.sv
module gpio_mp_sync #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] held;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta = async_i;
        s_d.held = s_q.meta;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign sync_o = s_q.held;
endmodule

// File: rtl/gpio_mp_setclr.sv
module gpio_mp_setclr #(
    parameter int           W    = 8,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         set_i,
    input  logic         clr_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } word_t;

    word_t r_d, r_q;
    logic [W-1:0] eff_mask;

    always_comb begin
        eff_mask = mask_i & KEEP;
        r_d = r_q;
        if (set_i)      r_d.bits = r_q.bits | eff_mask;
        else if (clr_i) r_d.bits = r_q.bits & ~eff_mask;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign q_o = r_q.bits;
endmodule

// File: rtl/gpio_mp_rdmux.sv
module gpio_mp_rdmux
    import gpio_mp_pkg::*;
(
    input  rd_view_t              view_i,
    input  logic [WIDX_W-1:0]     widx_i,
    input  logic                  hit_i,
    output logic [DATA_W-1:0]     rdata_o
);
    logic [DATA_W-1:0] rdata_d;

    always_comb begin
        rdata_d = '0;
        if (hit_i) begin
            case (widx_i)
                WI_B0_IN:  rdata_d = DATA_W'(view_i.b0_in);
                WI_B0_OST: rdata_d = DATA_W'(view_i.b0_out);
                WI_B0_DST: rdata_d = DATA_W'(view_i.b0_dir);
                WI_B1_IN:  rdata_d = DATA_W'(view_i.b1_in);
                WI_B1_OST: rdata_d = DATA_W'(view_i.b1_out);
                WI_B1_DST: rdata_d = DATA_W'(view_i.b1_dir);
                WI_B2_IN:  rdata_d = DATA_W'(view_i.b2_in);
                WI_B2_DST: rdata_d = DATA_W'(view_i.b2_dir);
                WI_RT_ST:  rdata_d = DATA_W'(view_i.route);
                WI_B3_IN:  rdata_d = DATA_W'(view_i.b3_in);
                WI_B3_OST: rdata_d = DATA_W'(view_i.b3_out);
                default:   rdata_d = '0;
            endcase
        end
    end

    assign rdata_o = rdata_d;
endmodule

// File: rtl/gpio_multiport.sv
module gpio_multiport
    import gpio_mp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic                 bus_we_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    input  logic [B0_W-1:0]      b0_pad_i,
    output logic [B0_W-1:0]      b0_pad_o,
    output logic [B0_W-1:0]      b0_pad_oe_o,
    input  logic [B1_W-1:0]      b1_pad_i,
    output logic [B1_W-1:0]      b1_pad_o,
    output logic [B1_W-1:0]      b1_pad_oe_o,
    input  logic [B2_W-1:0]      b2_pad_i,
    output logic [B2_W-1:0]      b2_pad_o,
    output logic [B2_W-1:0]      b2_pad_oe_o,
    input  logic [B3_IO_W-1:0]   b3_io_i,
    output logic [B3_IO_W-1:0]   b3_io_o,
    output logic [B3_IO_W-1:0]   b3_io_oe_o,
    input  logic [B3_DIN_W-1:0]  b3_din_i,
    output logic [B3_DOUT_W-1:0] b3_dout_o,
    output logic [ROUTE_W-1:0]   route_sel_o
);
    // ---------------- address decode ----------------
    logic [WIDX_W-1:0] widx;
    logic              hit;
    wr_stb_t           stb_d;

    assign widx = bus_addr_i[WIDX_W+1:2];
    assign hit  = ((bus_addr_i >> (WIDX_W + 2)) == '0) && (bus_addr_i[1:0] == 2'b00);

    always_comb begin
        stb_d = '0;
        if (bus_we_i && hit) begin
            case (widx)
                WI_B0_OSET: stb_d.b0_oset = 1'b1;
                WI_B0_OCLR: stb_d.b0_oclr = 1'b1;
                WI_B0_DSET: stb_d.b0_dset = 1'b1;
                WI_B0_DCLR: stb_d.b0_dclr = 1'b1;
                WI_B1_OSET: stb_d.b1_oset = 1'b1;
                WI_B1_OCLR: stb_d.b1_oclr = 1'b1;
                WI_B1_DSET: stb_d.b1_dset = 1'b1;
                WI_B1_DCLR: stb_d.b1_dclr = 1'b1;
                WI_B2_OSET: stb_d.b2_oset = 1'b1;
                WI_B2_OCLR: stb_d.b2_oclr = 1'b1;
                WI_B2_DSET: stb_d.b2_dset = 1'b1;
                WI_B2_DCLR: stb_d.b2_dclr = 1'b1;
                WI_B3_OSET: stb_d.b3_oset = 1'b1;
                WI_B3_OCLR: stb_d.b3_oclr = 1'b1;
                WI_RT_SET:  stb_d.rt_set  = 1'b1;
                WI_RT_CLR:  stb_d.rt_clr  = 1'b1;
                default: ;
            endcase
        end
    end

    // ---------------- input synchronizers ----------------
    logic [SYNC_W-1:0]   sync_s;
    logic [B3_DIN_W-1:0] b3_in_d;

    gpio_mp_sync #(.W(SYNC_W)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i ({b3_din_i, b3_io_i, b2_pad_i, b1_pad_i, b0_pad_i}),
        .sync_o  (sync_s)
    );

    // bank 3 input word: shared positions belong to the bidirectional pins
    always_comb begin
        b3_in_d = sync_s[SY_DIN +: B3_DIN_W] & B3_DIN_VALID;
        b3_in_d[B3_IN_LO_LSB +: B3_IO_W-1] = sync_s[SY_IO +: B3_IO_W-1];
        b3_in_d[B3_IN_LAST]                = sync_s[SY_IO + B3_IO_W - 1];
    end

    // ---------------- stored words ----------------
    logic [B0_W-1:0]    b0_out_q, b0_dir_q;
    logic [B1_W-1:0]    b1_out_q, b1_dir_q;
    logic [B2_W-1:0]    b2_out_q;
    logic [CTL_W-1:0]   b2_dir_q, b3_out_q;
    logic [ROUTE_W-1:0] route_q;

    gpio_mp_setclr #(.W(B0_W)) u_b0_out (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stb_d.b0_oset), .clr_i(stb_d.b0_oclr),
        .mask_i(bus_wdata_i[B0_W-1:0]), .q_o(b0_out_q));
    gpio_mp_setclr #(.W(B0_W)) u_b0_dir (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stb_d.b0_dset), .clr_i(stb_d.b0_dclr),
        .mask_i(bus_wdata_i[B0_W-1:0]), .q_o(b0_dir_q));
    gpio_mp_setclr #(.W(B1_W)) u_b1_out (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stb_d.b1_oset), .clr_i(stb_d.b1_oclr),
        .mask_i(bus_wdata_i[B1_W-1:0]), .q_o(b1_out_q));
    gpio_mp_setclr #(.W(B1_W)) u_b1_dir (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stb_d.b1_dset), .clr_i(stb_d.b1_dclr),
        .mask_i(bus_wdata_i[B1_W-1:0]), .q_o(b1_dir_q));
    gpio_mp_setclr #(.W(B2_W)) u_b2_out (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stb_d.b2_oset), .clr_i(stb_d.b2_oclr),
        .mask_i(bus_wdata_i[B2_W-1:0]), .q_o(b2_out_q));
    gpio_mp_setclr #(.W(CTL_W), .KEEP(B2_DIR_KEEP)) u_b2_dir (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stb_d.b2_dset), .clr_i(stb_d.b2_dclr),
        .mask_i(bus_wdata_i[CTL_W-1:0]), .q_o(b2_dir_q));
    gpio_mp_setclr #(.W(CTL_W), .KEEP(B3_OUT_KEEP)) u_b3_out (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stb_d.b3_oset), .clr_i(stb_d.b3_oclr),
        .mask_i(bus_wdata_i[CTL_W-1:0]), .q_o(b3_out_q));
    gpio_mp_setclr #(.W(ROUTE_W)) u_route (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(stb_d.rt_set), .clr_i(stb_d.rt_clr),
        .mask_i(bus_wdata_i[ROUTE_W-1:0]), .q_o(route_q));

    // ---------------- read path ----------------
    rd_view_t view;

    always_comb begin
        view.b0_in  = sync_s[SY_B0 +: B0_W];
        view.b0_out = b0_out_q;
        view.b0_dir = b0_dir_q;
        view.b1_in  = sync_s[SY_B1 +: B1_W];
        view.b1_out = b1_out_q;
        view.b1_dir = b1_dir_q;
        view.b2_in  = sync_s[SY_B2 +: B2_W];
        view.b2_dir = b2_dir_q;
        view.route  = route_q;
        view.b3_in  = b3_in_d;
        view.b3_out = b3_out_q;
    end

    gpio_mp_rdmux u_rdmux (
        .view_i  (view),
        .widx_i  (widx),
        .hit_i   (hit),
        .rdata_o (bus_rdata_o)
    );

    // ---------------- pad side ----------------
    assign b0_pad_o    = b0_out_q;
    assign b0_pad_oe_o = b0_dir_q;
    assign b1_pad_o    = b1_out_q;
    assign b1_pad_oe_o = b1_dir_q;
    assign b2_pad_o    = b2_out_q;
    assign b2_pad_oe_o = b2_dir_q[B2_W-1:0];
    assign b3_io_o     = b3_out_q[B3_IO_LSB +: B3_IO_W];
    assign b3_io_oe_o  = b2_dir_q[B3_IO_LSB +: B3_IO_W];
    assign b3_dout_o   = b3_out_q[B3_DOUT_W-1:0];
    assign route_sel_o = route_q;
endmodule

// File: rtl/gpio_multiport_chk.sv
module gpio_multiport_chk
    import gpio_mp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic                 bus_we_i,
    input logic [DATA_W-1:0]    bus_wdata_i,
    input logic [DATA_W-1:0]    bus_rdata_o,
    input logic [B0_W-1:0]      b0_pad_o,
    input logic [B0_W-1:0]      b0_pad_oe_o,
    input logic [B2_W-1:0]      b2_pad_o,
    input logic [B3_IO_W-1:0]   b3_io_oe_o,
    input logic [B3_DOUT_W-1:0] b3_dout_o,
    input logic [ROUTE_W-1:0]   route_sel_o
);
    localparam logic [ADDR_W-1:0] A_B3_OSET = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] A_B3_OST  = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] A_B2_DST  = ADDR_W'(8'h18);
    localparam logic [ADDR_W-1:0] A_RT_SET  = ADDR_W'(8'h28);
    localparam logic [ADDR_W-1:0] A_B0_OSET = ADDR_W'(8'h44);
    localparam logic [ADDR_W-1:0] A_B0_OCLR = ADDR_W'(8'h48);
    localparam logic [ADDR_W-1:0] A_B0_DSET = ADDR_W'(8'h50);
    localparam logic [ADDR_W-1:0] A_B0_DCLR = ADDR_W'(8'h54);
    localparam logic [ADDR_W-1:0] A_B1_DSET = ADDR_W'(8'h70);

    a_r2_set_raises_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == A_B0_OSET) |=>
            ((b0_pad_o & $past(bus_wdata_i[B0_W-1:0])) == $past(bus_wdata_i[B0_W-1:0])) &&
            ((b0_pad_o & ~$past(bus_wdata_i[B0_W-1:0])) ==
             ($past(b0_pad_o) & ~$past(bus_wdata_i[B0_W-1:0]))));

    a_r3_clear_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == A_B0_OCLR) |=>
            ((b0_pad_o & $past(bus_wdata_i[B0_W-1:0])) == '0));

    a_r4_oe_holds_without_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_we_i && (bus_addr_i == A_B0_DSET || bus_addr_i == A_B0_DCLR)) |=>
            $stable(b0_pad_oe_o));

    a_r5_strobe_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == A_B3_OSET || bus_addr_i == A_B0_OSET || bus_addr_i == A_B1_DSET) |->
            (bus_rdata_o == '0));

    a_r6_route_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i == A_RT_SET) |=>
            ((route_sel_o & $past(bus_wdata_i)) == $past(bus_wdata_i)));

    a_r7_io_enable_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == A_B2_DST) |-> (bus_rdata_o[B3_IO_LSB +: B3_IO_W] == b3_io_oe_o));

    a_r8_dout_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == A_B3_OST) |-> (bus_rdata_o[B3_DOUT_W-1:0] == b3_dout_o));

    a_r11_misaligned_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_we_i && bus_addr_i[1:0] != 2'b00) |=>
            $stable({b0_pad_o, b0_pad_oe_o, b2_pad_o, b3_dout_o, route_sel_o}));
endmodule

bind gpio_multiport gpio_multiport_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_addr_i  (bus_addr_i),
    .bus_we_i    (bus_we_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .b0_pad_o    (b0_pad_o),
    .b0_pad_oe_o (b0_pad_oe_o),
    .b2_pad_o    (b2_pad_o),
    .b3_io_oe_o  (b3_io_oe_o),
    .b3_dout_o   (b3_dout_o),
    .route_sel_o (route_sel_o)
);

// File: tb/gpio_multiport_bench.sv
module gpio_multiport_bench;
    timeunit 1ns;
    timeprecision 100ps;
    import gpio_mp_pkg::*;

    localparam int S_RD = 0, S_B0 = 1, S_B1O = 2, S_B1E = 3, S_B2 = 4,
                   S_B3IO = 5, S_DOUT = 6, S_RT = 7;

    logic clk = 1'b0;
    logic rst_n;
    logic [7:0]  addr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [B0_W-1:0] b0_i, b0_o, b0_oe;
    logic [B1_W-1:0] b1_i, b1_o, b1_oe;
    logic [B2_W-1:0] b2_i, b2_o, b2_oe;
    logic [B3_IO_W-1:0] io_i, io_o, io_oe;
    logic [B3_DIN_W-1:0] din;
    logic [B3_DOUT_W-1:0] dout;
    logic [ROUTE_W-1:0] route;

    longint cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    typedef struct {
        int          src;
        logic [31:0] exp;
        string       req;
        string       what;
        longint      due;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gpio_multiport u_gpio_multiport (
        .clk_i(clk), .rst_ni(rst_n),
        .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .b0_pad_i(b0_i), .b0_pad_o(b0_o), .b0_pad_oe_o(b0_oe),
        .b1_pad_i(b1_i), .b1_pad_o(b1_o), .b1_pad_oe_o(b1_oe),
        .b2_pad_i(b2_i), .b2_pad_o(b2_o), .b2_pad_oe_o(b2_oe),
        .b3_io_i(io_i), .b3_io_o(io_o), .b3_io_oe_o(io_oe),
        .b3_din_i(din), .b3_dout_o(dout), .route_sel_o(route)
    );

    function automatic logic [31:0] observe(input int s);
        case (s)
            S_RD:    return rdata;
            S_B0:    return 32'({b0_oe, b0_o});
            S_B1O:   return 32'(b1_o);
            S_B1E:   return 32'(b1_oe);
            S_B2:    return 32'({b2_oe, b2_o});
            S_B3IO:  return 32'({io_oe, io_o});
            S_DOUT:  return 32'(dout);
            default: return route;
        endcase
    endfunction

    // monitor: pops due expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            exp_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = observe(it.src);
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s %s: actual 0x%08h expected 0x%08h", it.req, it.what, act, it.exp);
            end
        end
    end

    task automatic expect_sig(input int s, input logic [31:0] e, input string r, input string w);
        exp_t it;
        it.src = s; it.exp = e; it.req = r; it.what = w; it.due = cyc;
        sb.push_back(it);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; we = 1'b1; wdata = d;
        @(posedge clk); #1;
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string r);
        addr = a; we = 1'b0;
        expect_sig(S_RD, e, r, $sformatf("read 0x%02h", a));
        @(posedge clk); #1;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0;
        b0_i = '0; b1_i = '0; b2_i = '0; io_i = '0; din = '0;
        settle(3);
        rst_n = 1'b1;

        // R1 reset state
        expect_sig(S_B0, 0, "R1", "bank0 pads");
        expect_sig(S_B1O, 0, "R1", "bank1 out");
        expect_sig(S_B1E, 0, "R1", "bank1 oe");
        expect_sig(S_B2, 0, "R1", "bank2 pads");
        expect_sig(S_B3IO, 0, "R1", "bank3 io");
        expect_sig(S_DOUT, 0, "R1", "output-only lines");
        expect_sig(S_RT, 0, "R1", "routing");
        rd(8'h4C, 0, "R1"); rd(8'h58, 0, "R1"); rd(8'h18, 0, "R1");
        rd(8'h0C, 0, "R1"); rd(8'h30, 0, "R1"); rd(8'h00, 0, "R1");

        // R2 raise, zero bits untouched
        wr(8'h44, 32'h05); expect_sig(S_B0, 32'h0005, "R2", "bank0 set 05");
        wr(8'h44, 32'h80); expect_sig(S_B0, 32'h0085, "R2", "bank0 set 80 keeps 05");
        rd(8'h4C, 32'h85, "R2");
        // R3 lower
        wr(8'h48, 32'h04); expect_sig(S_B0, 32'h0081, "R3", "bank0 clear 04");
        rd(8'h4C, 32'h81, "R3");
        // R4 direction
        wr(8'h50, 32'h0F); expect_sig(S_B0, 32'h0F81, "R4", "bank0 oe set");
        wr(8'h54, 32'h03); expect_sig(S_B0, 32'h0C81, "R4", "bank0 oe clear");
        rd(8'h58, 32'h0C, "R4");
        // R5 strobe addresses read zero
        rd(8'h44, 0, "R5"); rd(8'h48, 0, "R5"); rd(8'h50, 0, "R5");
        rd(8'h04, 0, "R5"); rd(8'h10, 0, "R5"); rd(8'h28, 0, "R5");
        // R12 bits beyond width dropped
        wr(8'h44, 32'hFFFF_FF00); expect_sig(S_B0, 32'h0C81, "R12", "bank0 wide set");
        wr(8'h50, 32'hFFFF_FF00); expect_sig(S_B0, 32'h0C81, "R12", "bank0 wide dir");
        rd(8'h4C, 32'h81, "R12");
        // bank 1 (R2, R3, R4)
        wr(8'h64, 32'hABCDEF); expect_sig(S_B1O, 32'hABCDEF, "R2", "bank1 set");
        wr(8'h68, 32'h0000EF); expect_sig(S_B1O, 32'hABCD00, "R3", "bank1 clear");
        rd(8'h6C, 32'hABCD00, "R4");
        wr(8'h70, 32'hFFFFFF); wr(8'h74, 32'h0000F0);
        expect_sig(S_B1E, 32'hFFFF0F, "R4", "bank1 oe");
        rd(8'h78, 32'hFFFF0F, "R4");
        // R6 bank 2 and routing, R12 for bank 2 width
        wr(8'h20, 32'hFFFF_FFFF);
        expect_sig(S_B2, 32'h1FFF, "R12", "bank2 out width");
        expect_sig(S_B3IO, 0, "R12", "bank2 set leaves bank3 io");
        wr(8'h24, 32'h1000); expect_sig(S_B2, 32'h0FFF, "R6", "bank2 clear");
        wr(8'h10, 32'h1);    expect_sig(S_B2, 32'h2FFF, "R6", "bank2 oe");
        wr(8'h28, 32'hDEAD_BEEF); expect_sig(S_RT, 32'hDEAD_BEEF, "R6", "route set");
        wr(8'h2C, 32'h0000_FFFF); expect_sig(S_RT, 32'hDEAD_0000, "R6", "route clear");
        rd(8'h30, 32'hDEAD_0000, "R6");
        rd(8'h18, 32'h0000_0001, "R6");
        // R7 bank 3 bidirectional control at bit n+25
        wr(8'h04, 32'h4200_0000); expect_sig(S_B3IO, 32'h021, "R7", "io out pins 0,5");
        wr(8'h10, 32'h0800_0000); expect_sig(S_B3IO, 32'h121, "R7", "io oe pin 2");
        expect_sig(S_B2, 32'h2FFF, "R7", "bank2 pads untouched");
        rd(8'h18, 32'h0800_0001, "R7");
        wr(8'h14, 32'h0800_0000); expect_sig(S_B3IO, 32'h021, "R7", "io oe cleared");
        wr(8'h08, 32'h0200_0000); expect_sig(S_B3IO, 32'h020, "R7", "io out pin0 cleared");
        // R8 output-only lines
        wr(8'h04, 32'h00A5_A5A5); expect_sig(S_DOUT, 32'hA5A5A5, "R8", "dout set");
        expect_sig(S_B3IO, 32'h020, "R8", "dout write leaves io");
        wr(8'h08, 32'h0000_00FF); expect_sig(S_DOUT, 32'hA5A500, "R8", "dout clear");
        rd(8'h0C, 32'h40A5_A500, "R8");
        // R9 two-stage input latency
        b0_i = 8'h3C;
        rd(8'h40, 0, "R9"); rd(8'h40, 0, "R9"); rd(8'h40, 32'h3C, "R9");
        b1_i = 24'h123456; b2_i = 13'h1ABC;
        settle(2);
        rd(8'h60, 32'h123456, "R9"); rd(8'h1C, 32'h1ABC, "R9");
        // R10 bank 3 input word
        din = 28'hFFF_FFFF; io_i = '0; settle(2);
        rd(8'h00, 32'h0EFF_83FF, "R10");
        din = '0; io_i = 6'h3F; settle(2);
        rd(8'h00, 32'h0100_7C00, "R10");
        io_i = 6'b100101; settle(2);
        rd(8'h00, 32'h0100_1400, "R10");
        din = 28'h100_7C00; io_i = '0; settle(2);
        rd(8'h00, 0, "R10");
        // R11 unmapped and misaligned
        wr(8'h34, 32'hFFFF_FFFF); wr(8'hC4, 32'hFFFF_FFFF);
        wr(8'h45, 32'hFFFF_FFFF); wr(8'hAC, 32'hFFFF_FFFF);
        expect_sig(S_B0, 32'h0C81, "R11", "bank0 after unmapped writes");
        expect_sig(S_RT, 32'hDEAD_0000, "R11", "route after unmapped writes");
        rd(8'h34, 0, "R11"); rd(8'hC0, 0, "R11"); rd(8'h41, 0, "R11"); rd(8'h7C, 0, "R11");

        settle(3);
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            summary();
            $finish;
        end
    end
endmodule